// File: doc/BRIEF.md
# Dithered High-Resolution PWM Generator

This block drives a single PWM pin from a 16-bit duty word, reaching 16-bit average resolution from a short 64-clock carrier. Time is cut into carrier periods of 2^CW clocks, and 2^FW periods make one frame. Within each period the pin is high for a coarse number of clocks and low for the rest. The coarse count comes from the upper CW bits of the word.

The lower FW bits form a fine value. Each set fine bit lengthens a group of periods by one clock. The groups are spread evenly through the frame in bit-reversed order, so the extra clocks are dithered across the frame instead of bunched together. The frame's average duty is therefore (n·2^FW + m) / 2^(CW+FW).

The duty word is double-buffered. A new word is taken only at a frame boundary, and it follows the input freely while the block is disabled.

Top module: `bmpwm_gen`

## Requirements
- R1: A carrier period lasts 2^CW clocks (default 64). A frame holds 2^FW periods (default 1024), indexed 0 to 2^FW-1. The waveform repeats every frame for a constant word.
- R2: The duty word splits into the coarse width n, taken from bits [CW+FW-1:FW], and the fine value m, taken from bits [FW-1:0].
- R3: In each period the pin is high for the first w clocks and low for the remaining clocks, where w is n or n+1. The pin is registered: frame clock c appears on the pin in the cycle after the c-th rising edge, counting from the first edge at which enable is sampled high.
- R4: With m = 0 no period is lengthened. With n = 0 and m = 0 the pin stays low.
- R5: Bit k of m lengthens by exactly one clock the periods whose index is an odd multiple of 2^(FW-1-k). For the defaults this means: bit 0 lengthens period 512, bit 9 lengthens every odd period, and period 0 is never lengthened.
- R6: Over one frame the pin is high for exactly n·2^FW + m clocks.
- R7: A word applied in the middle of a frame has no effect until the next frame begins. The word is captured at the last clock of each frame.
- R8: While enable is low, the pin is low from the next cycle on, both counters return to zero, and the buffered word follows the input. On re-enable, a new frame starts at period 0.
- R9: Synchronous reset clears the pin, both counters and the buffered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the generator idle |
| cmp_word | input | CW+FW | Duty word: coarse width above, fine value below |
| pwm_out | output | 1 | Registered PWM pin |

## Verification
The bench runs the generator with small parameters (16-clock periods, 32-period frames) and compares every clock of whole frames against a model. The model builds the stretched set per fine bit from odd multiples rather than from trailing zeros.

Single fine bits at the two extremes (only the middle period, and every odd period) confirm the bit-reversed ordering and rule out an off-by-one in the index. A mixed fine value with mid-range coarse width shows that the groups combine without overlap. The all-zero word, the zero-fine word and the near-full word cover the constant-low case and the case where a stretched period fills the whole carrier.

A mid-frame word change, together with an enable drop and restart, separates correct frame-boundary loading from immediate loading, and separates a counter restart from free running.

// File: rtl/bmpwm_pkg.sv
package bmpwm_pkg;

    // Default geometry: 64-clock carrier, 1024 carriers per frame.
    localparam int unsigned DEF_CW = 6;
    localparam int unsigned DEF_FW = 10;

    // Run state of the time base.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    // Position of the time base inside a frame.
    typedef struct packed {
        logic last_sub;   // final clock of a carrier period
        logic last_idx;   // final carrier period of a frame
    } frame_pos_t;

endpackage

// File: rtl/bmpwm_timebase.sv
module bmpwm_timebase
    import bmpwm_pkg::*;
#(
    parameter int unsigned CW = DEF_CW,
    parameter int unsigned FW = DEF_FW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic [CW-1:0] sub_cnt,
    output logic [FW-1:0] pulse_idx,
    output logic          frame_last
);

    localparam logic [CW-1:0] SUB_MAX = {CW{1'b1}};
    localparam logic [FW-1:0] IDX_MAX = {FW{1'b1}};
    localparam logic [CW-1:0] SUB_ONE = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [FW-1:0] IDX_ONE = {{(FW-1){1'b0}}, 1'b1};

    run_state_t    state_q;
    logic [CW-1:0] sub_q;
    logic [FW-1:0] idx_q;
    frame_pos_t    pos;

    assign pos.last_sub = (sub_q == SUB_MAX);
    assign pos.last_idx = (idx_q == IDX_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sub_q   <= '0;
            idx_q   <= '0;
        end else if (!en) begin
            state_q <= ST_IDLE;
            sub_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= ST_RUN;
            sub_q   <= sub_q + SUB_ONE;
            if (pos.last_sub) begin
                idx_q <= idx_q + IDX_ONE;
            end
        end
    end

    assign sub_cnt    = sub_q;
    assign pulse_idx  = idx_q;
    assign frame_last = en && pos.last_sub && pos.last_idx;

endmodule

// File: rtl/bmpwm_shadow.sv
module bmpwm_shadow #(
    parameter int unsigned CMPW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            frame_last,
    input  logic [CMPW-1:0] word_in,
    output logic [CMPW-1:0] word_act
);

    logic [CMPW-1:0] act_q;

    // Follows the input while idle; otherwise reloads on the last clock of a frame.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (!en || frame_last) begin
            act_q <= word_in;
        end
    end

    assign word_act = act_q;

endmodule

// File: rtl/bmpwm_stretch.sv
module bmpwm_stretch #(
    parameter int unsigned FW = 10
) (
    input  logic [FW-1:0] pulse_idx,
    input  logic [FW-1:0] fine,
    output logic          stretch
);

    logic [FW-1:0] hit;

    // Fine bit k owns the periods at odd multiples of 2^(FW-1-k):
    // that bit of the index is set and every bit below it is clear.
    for (genvar k = 0; k < FW; k++) begin : g_bit
        localparam int unsigned POS = FW - 1 - k;
        localparam logic [FW-1:0] LOW_MASK = FW'((64'd1 << POS) - 64'd1);
        assign hit[k] = fine[k] && pulse_idx[POS] && ((pulse_idx & LOW_MASK) == '0);
    end

    assign stretch = |hit;

endmodule

// File: rtl/bmpwm_outstage.sv
module bmpwm_outstage #(
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] sub_cnt,
    input  logic [CW-1:0] coarse,
    input  logic          stretch,
    output logic          pin
);

    logic [CW:0] width;
    logic        pin_q;

    assign width = {1'b0, coarse} + {{CW{1'b0}}, stretch};

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else begin
            pin_q <= en && ({1'b0, sub_cnt} < width);
        end
    end

    assign pin = pin_q;

endmodule

// File: rtl/bmpwm_gen.sv
module bmpwm_gen
    import bmpwm_pkg::*;
#(
    parameter int unsigned CW = DEF_CW,
    parameter int unsigned FW = DEF_FW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CW+FW-1:0] cmp_word,
    output logic             pwm_out
);

    localparam int unsigned CMPW = CW + FW;

    logic [CW-1:0]   sub_cnt;
    logic [FW-1:0]   pulse_idx;
    logic            frame_last;
    logic [CMPW-1:0] act_word;
    logic [CW-1:0]   coarse;
    logic [FW-1:0]   fine;
    logic            stretch;

    bmpwm_timebase #(.CW(CW), .FW(FW)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .sub_cnt   (sub_cnt),
        .pulse_idx (pulse_idx),
        .frame_last(frame_last)
    );

    bmpwm_shadow #(.CMPW(CMPW)) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .frame_last(frame_last),
        .word_in   (cmp_word),
        .word_act  (act_word)
    );

    assign coarse = act_word[CMPW-1:FW];
    assign fine   = act_word[FW-1:0];

    bmpwm_stretch #(.FW(FW)) u_stretch (
        .pulse_idx(pulse_idx),
        .fine     (fine),
        .stretch  (stretch)
    );

    bmpwm_outstage #(.CW(CW)) u_out (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .sub_cnt(sub_cnt),
        .coarse (coarse),
        .stretch(stretch),
        .pin    (pwm_out)
    );

endmodule

// File: rtl/bmpwm_gen_chk.sv
module bmpwm_gen_chk #(
    parameter int unsigned CW = 6,
    parameter int unsigned FW = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             pin,
    input logic [CW-1:0]    sub_cnt,
    input logic [FW-1:0]    pulse_idx,
    input logic [CW+FW-1:0] act_word
);

    localparam logic [CW-1:0] SUB_MAX = {CW{1'b1}};
    localparam logic [FW-1:0] IDX_MAX = {FW{1'b1}};
    localparam logic [FW-1:0] IDX_ONE = {{(FW-1){1'b0}}, 1'b1};

    logic [CW-1:0] coarse_c;
    assign coarse_c = act_word[CW+FW-1:FW];

    // R1: carrier period wraps after 2^CW clocks
    assert_sub_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (en && sub_cnt == SUB_MAX) |=> (sub_cnt == '0));

    // R1: period index advances once per carrier wrap
    assert_idx_step_R1: assert property (@(posedge clk) disable iff (rst)
        (en && sub_cnt == SUB_MAX) |=> (pulse_idx == $past(pulse_idx) + IDX_ONE));

    // R3: clocks past the widest possible pulse are low
    assert_low_tail_R3: assert property (@(posedge clk) disable iff (rst)
        (en && sub_cnt > coarse_c) |=> !pin);

    // R3: clocks inside the coarse width are high
    assert_high_head_R3: assert property (@(posedge clk) disable iff (rst)
        (en && sub_cnt < coarse_c) |=> pin);

    // R5: period 0 never gets the extra clock
    assert_pulse0_R5: assert property (@(posedge clk) disable iff (rst)
        (en && pulse_idx == '0 && sub_cnt == coarse_c) |=> !pin);

    // R7: buffered word holds except at the frame's last clock
    assert_word_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !(sub_cnt == SUB_MAX && pulse_idx == IDX_MAX)) |=> $stable(act_word));

    // R8: idle drives the pin low and clears the counters
    assert_idle_low_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!pin && sub_cnt == '0 && pulse_idx == '0));

    // R9: reset clears pin and counters
    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (!pin && sub_cnt == '0 && pulse_idx == '0 && act_word == '0));

endmodule

bind bmpwm_gen bmpwm_gen_chk #(.CW(CW), .FW(FW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .pin      (pwm_out),
    .sub_cnt  (sub_cnt),
    .pulse_idx(pulse_idx),
    .act_word (act_word)
);

// File: tb/test_bmpwm_gen.sv
module test_bmpwm_gen;

    localparam int CLK_PERIOD = 10;
    localparam int CW   = 4;
    localparam int FW   = 5;
    localparam int P    = 1 << CW;
    localparam int NP   = 1 << FW;
    localparam int FRAME = P * NP;
    localparam int CMPW = CW + FW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            en  = 1'b0;
    logic [CMPW-1:0] cmp_word = '0;
    logic            pwm_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bmpwm_gen #(.CW(CW), .FW(FW)) i_bmpwm_gen (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .cmp_word(cmp_word),
        .pwm_out (pwm_out)
    );

    function automatic logic [CMPW-1:0] mk(input int n, input int m);
        return CMPW'((n << FW) | m);
    endfunction

    // Model: fine bit k owns the odd multiples of 2^(FW-1-k).
    function automatic logic ref_level(input logic [CMPW-1:0] w, input int c);
        int n;
        int m;
        int t;
        int s;
        int extra;
        n = int'(w >> FW);
        m = int'(w) & (NP - 1);
        t = (c / P) % NP;
        s = c % P;
        extra = 0;
        for (int k = 0; k < FW; k++) begin
            int sp;
            sp = 1 << (FW - 1 - k);
            if (((m >> k) & 1) == 1 && (t % (2 * sp)) == sp) extra = 1;
        end
        return (s < n + extra);
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Hold idle with word w, then enable; the first sample is frame clock 0.
    task automatic start(input logic [CMPW-1:0] w);
        @(negedge clk);
        en = 1'b0;
        cmp_word = w;
        repeat (2) @(negedge clk);
        en = 1'b1;
    endtask

    // Compare one whole frame clock by clock and count the high clocks.
    task automatic frame_check(input logic [CMPW-1:0] w, input string req, input int switch_at,
                               input logic [CMPW-1:0] w_next);
        int bad;
        int first_bad;
        int first_act;
        int highs;
        int n;
        int m;
        bad = 0; first_bad = -1; first_act = 0; highs = 0;
        for (int c = 0; c < FRAME; c++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (pwm_out !== ref_level(w, c)) begin
                if (bad == 0) begin first_bad = c; first_act = int'(pwm_out); end
                bad++;
            end
            if (c == switch_at) cmp_word = w_next;
        end
        check(bad == 0, req, $sformatf("pattern word 0x%0h first bad clock %0d level", w, first_bad),
              first_act, 1 - first_act);
        n = int'(w >> FW);
        m = int'(w) & (NP - 1);
        check(highs == n * NP + m, "R6", $sformatf("high clocks per frame for word 0x%0h", w),
              highs, n * NP + m);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R9", "pin during reset", int'(pwm_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b0, "R9", "pin after reset, idle", int'(pwm_out), 0);
    endtask

    task automatic t_coarse_only;
        start(mk(5, 0));
        frame_check(mk(5, 0), "R4 R2 R3", -1, '0);
        frame_check(mk(5, 0), "R1", -1, '0);
    endtask

    task automatic t_all_zero;
        start(mk(0, 0));
        frame_check(mk(0, 0), "R4", -1, '0);
    endtask

    task automatic t_single_bits;
        start(mk(3, 1));
        frame_check(mk(3, 1), "R5 middle period only", -1, '0);
        start(mk(3, 1 << (FW - 1)));
        frame_check(mk(3, 1 << (FW - 1)), "R5 odd periods", -1, '0);
    endtask

    task automatic t_mixed;
        start(mk(7, 5'b10110));
        frame_check(mk(7, 5'b10110), "R5 R2 mixed", -1, '0);
    endtask

    task automatic t_full;
        start(mk(P - 1, NP - 1));
        frame_check(mk(P - 1, NP - 1), "R3 R5 full width", -1, '0);
    endtask

    task automatic t_midframe;
        start(mk(4, 3));
        frame_check(mk(4, 3), "R7 old word kept", 100, mk(9, 20));
        frame_check(mk(9, 20), "R7 new word at next frame", -1, '0);
    endtask

    task automatic t_disable;
        start(mk(6, 9));
        repeat (37) @(negedge clk);
        en = 1'b0;
        cmp_word = mk(11, 17);
        @(negedge clk);
        check(pwm_out == 1'b0, "R8", "pin one cycle after disable", int'(pwm_out), 0);
        repeat (3) @(negedge clk);
        check(pwm_out == 1'b0, "R8", "pin while idle", int'(pwm_out), 0);
        en = 1'b1;
        frame_check(mk(11, 17), "R8 restart at period 0 with idle word", -1, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_coarse_only();
        t_all_zero();
        t_single_bits();
        t_mixed();
        t_full();
        t_midframe();
        t_disable();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule